// File: doc/BRIEF.md
# Hex-Digit Stored-Program Processor Core

This block is a small processor that runs programs held in its own 256-byte memory. It has sixteen 8-bit working registers, an 8-bit program counter and a 16-bit instruction holding register. Every instruction is two bytes long. The top hex digit picks the operation and the other three digits name registers, an address or a literal.

The core repeats a three-phase cycle. It reads the high instruction byte, then the low byte, and then executes. Each instruction therefore takes exactly three clock cycles. The operations are:

- memory loads and stores
- literal loads
- register copy
- wrapping addition
- OR, AND and XOR
- rotate-right
- a compare-with-register-0 jump
- halt

A side port lets the environment write program and data bytes into memory, and read back any cell, while the core is held in reset or stopped. The `halted` output reports that the halt instruction has executed.

Top module: `hexcore_cpu`

## Requirements
- R1: While `rst` is high on a clock edge, the core clears the program counter to 00, clears all sixteen registers to 00 and drives `halted` low. The first instruction is fetched from address 00 on the first edge after `rst` falls.
- R2: The byte at PC is the high instruction byte (bits 15:12 opcode, 11:8 digit R) and the byte at PC+1 is the low byte (bits 7:4 digit S, 3:0 digit T; bits 7:0 form XY). PC advances by two and wraps modulo 256. Every instruction takes exactly three clock cycles, so `halted` rises 3N edges after reset release when N instructions have run, the halt included.
- R3: Opcode 1 (1RXY) loads register R from memory cell XY. Opcode 2 (2RXY) loads register R with the literal XY.
- R4: Opcode 3 (3RXY) writes register R into memory cell XY.
- R5: Opcode 4 (40ST) copies register S into register T.
- R6: Opcode 5 (5RST) writes S + T modulo 256 into register R, and the carry is lost.
- R7: Opcodes 7, 8 and 9 (xRST) write S OR T, S AND T and S XOR T respectively into register R.
- R8: Opcode A (AR0X) rotates register R right by X modulo 8 positions, so X of 0 or 8 leaves R unchanged.
- R9: Opcode B (BRXY) sets PC to XY when register R equals register 0, and otherwise falls through to PC+2. B0XY therefore always jumps.
- R10: Opcode C (C000) raises `halted`. From then until reset, PC, the registers and memory no longer change under program control.
- R11: Opcodes 0, 6, D, E and F change no register, no memory cell and no PC beyond the normal advance by two.
- R12: When `dbg_we` is high, a clock edge writes `dbg_wdata` into cell `dbg_addr`. `dbg_rdata` always shows the current content of cell `dbg_addr` without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dbg_we | input | 1 | Side-port write enable into memory |
| dbg_addr | input | 8 | Side-port memory address |
| dbg_wdata | input | 8 | Side-port write data |
| dbg_rdata | output | 8 | Content of the cell at `dbg_addr` |
| halted | output | 1 | High once the halt instruction has executed |

## Verification
Each instruction completes on the third rising edge after its fetch begins. A program of N instructions ending in halt therefore raises `halted` exactly 3N edges after reset release. The bench counts rising edges from the falling-edge release of `rst`, samples `halted` on each following falling edge, and compares the count with 3N. Register and memory effects are checked only after `halted` is seen: stores are read back through the combinational side port half a cycle later, and register values are brought out by storing them to memory. Freezing after halt is checked by idling for several cycles and then rereading `halted` and a cell that a later instruction would have written.

// File: rtl/hexcore_pkg.sv
package hexcore_pkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_BITS = 8;
  localparam int REG_COUNT = 16;
  localparam int NIB_W     = 4;
  localparam int INSTR_W   = 2 * DATA_W;

  localparam logic [NIB_W-1:0] OP_LDM = 4'h1;
  localparam logic [NIB_W-1:0] OP_LDI = 4'h2;
  localparam logic [NIB_W-1:0] OP_STM = 4'h3;
  localparam logic [NIB_W-1:0] OP_MOV = 4'h4;
  localparam logic [NIB_W-1:0] OP_ADD = 4'h5;
  localparam logic [NIB_W-1:0] OP_OR  = 4'h7;
  localparam logic [NIB_W-1:0] OP_AND = 4'h8;
  localparam logic [NIB_W-1:0] OP_XOR = 4'h9;
  localparam logic [NIB_W-1:0] OP_ROR = 4'hA;
  localparam logic [NIB_W-1:0] OP_JEQ = 4'hB;
  localparam logic [NIB_W-1:0] OP_HLT = 4'hC;

  typedef enum logic [1:0] {
    ST_FETCH_HI = 2'd0,
    ST_FETCH_LO = 2'd1,
    ST_EXEC     = 2'd2,
    ST_HALT     = 2'd3
  } cpu_state_e;

  // two's-complement sum, carry dropped
  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  // rotate right by amt modulo the data width
  function automatic logic [DATA_W-1:0] rot_right(input logic [DATA_W-1:0] v,
                                                  input logic [NIB_W-1:0] amt);
    logic [2*DATA_W-1:0] dbl;
    int unsigned         sh;
    sh  = 32'(amt) % DATA_W;
    dbl = {v, v} >> sh;
    return dbl[DATA_W-1:0];
  endfunction

endpackage

// File: rtl/hexcore_regs.sv
module hexcore_regs
  import hexcore_pkg::*;
#(
  parameter int NREG = REG_COUNT,
  parameter int DW   = DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(NREG)-1:0]  waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0]  ra_addr,
  output logic [DW-1:0]            ra_data,
  input  logic [$clog2(NREG)-1:0]  rb_addr,
  output logic [DW-1:0]            rb_data,
  input  logic [$clog2(NREG)-1:0]  rc_addr,
  output logic [DW-1:0]            rc_data,
  output logic [DW-1:0]            r0_data
);

  logic [DW-1:0] bank_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
    end else if (we) begin
      bank_q[waddr] <= wdata;
    end
  end

  assign ra_data = bank_q[ra_addr];
  assign rb_data = bank_q[rb_addr];
  assign rc_data = bank_q[rc_addr];
  assign r0_data = bank_q[0];

endmodule

// File: rtl/hexcore_mem.sv
module hexcore_mem
  import hexcore_pkg::*;
#(
  parameter int AW = ADDR_BITS,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells_q [DEPTH];

  // core store wins over the side port on a shared edge
  always_ff @(posedge clk) begin
    if (cpu_we) begin
      cells_q[cpu_addr] <= cpu_wdata;
    end else if (dbg_we) begin
      cells_q[dbg_addr] <= dbg_wdata;
    end
  end

  assign cpu_rdata = cells_q[cpu_addr];
  assign dbg_rdata = cells_q[dbg_addr];

endmodule

// File: rtl/hexcore_alu.sv
module hexcore_alu
  import hexcore_pkg::*;
(
  input  logic [NIB_W-1:0]  op,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] r_val,
  input  logic [DATA_W-1:0] s_val,
  input  logic [DATA_W-1:0] t_val,
  input  logic [NIB_W-1:0]  rot_amt,
  output logic [DATA_W-1:0] result,
  output logic              writes
);

  always_comb begin
    result = '0;
    writes = 1'b0;
    unique case (op)
      OP_LDM: begin result = mem_val;                   writes = 1'b1; end
      OP_LDI: begin result = imm;                       writes = 1'b1; end
      OP_MOV: begin result = s_val;                     writes = 1'b1; end
      OP_ADD: begin result = add_wrap(s_val, t_val);    writes = 1'b1; end
      OP_OR:  begin result = s_val | t_val;             writes = 1'b1; end
      OP_AND: begin result = s_val & t_val;             writes = 1'b1; end
      OP_XOR: begin result = s_val ^ t_val;             writes = 1'b1; end
      OP_ROR: begin result = rot_right(r_val, rot_amt); writes = 1'b1; end
      default: begin result = '0;                       writes = 1'b0; end
    endcase
  end

endmodule

// File: rtl/hexcore_cpu.sv
module hexcore_cpu
  import hexcore_pkg::*;
#(
  parameter int ADDR_W   = ADDR_BITS,
  parameter int NUM_REGS = REG_COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              halted
);

  localparam int RAW = $clog2(NUM_REGS);

  cpu_state_e          state_q;
  logic [ADDR_W-1:0]   pc_q;
  logic [INSTR_W-1:0]  ir_q;
  logic                halted_q;

  // instruction fields
  logic [NIB_W-1:0]  op;
  logic [RAW-1:0]    fld_r, fld_s, fld_t;
  logic [DATA_W-1:0] imm;
  assign op    = ir_q[INSTR_W-1 -: NIB_W];
  assign fld_r = ir_q[2*NIB_W +: RAW];
  assign fld_s = ir_q[NIB_W +: RAW];
  assign fld_t = ir_q[0 +: RAW];
  assign imm   = ir_q[DATA_W-1:0];

  // named events
  logic exec_fire, jump_taken, halt_fire, rf_we, mem_cpu_we, alu_writes;
  logic [DATA_W-1:0] ra_data, rb_data, rc_data, r0_data, mem_rdata, alu_result;
  logic [ADDR_W-1:0] cpu_addr;
  logic [RAW-1:0]    rf_waddr;

  assign exec_fire  = (state_q == ST_EXEC);
  assign jump_taken = exec_fire && (op == OP_JEQ) && (ra_data == r0_data);
  assign halt_fire  = exec_fire && (op == OP_HLT);
  assign mem_cpu_we = exec_fire && (op == OP_STM);
  assign rf_we      = exec_fire && alu_writes;
  assign rf_waddr   = (op == OP_MOV) ? fld_t : fld_r;
  assign cpu_addr   = exec_fire ? ADDR_W'(imm) : pc_q;

  hexcore_regs #(.NREG(NUM_REGS), .DW(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (alu_result),
    .ra_addr (fld_r),
    .ra_data (ra_data),
    .rb_addr (fld_s),
    .rb_data (rb_data),
    .rc_addr (fld_t),
    .rc_data (rc_data),
    .r0_data (r0_data)
  );

  hexcore_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk       (clk),
    .cpu_we    (mem_cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (ra_data),
    .cpu_rdata (mem_rdata),
    .dbg_we    (dbg_we),
    .dbg_addr  (dbg_addr),
    .dbg_wdata (dbg_wdata),
    .dbg_rdata (dbg_rdata)
  );

  hexcore_alu u_alu (
    .op      (op),
    .mem_val (mem_rdata),
    .imm     (imm),
    .r_val   (ra_data),
    .s_val   (rb_data),
    .t_val   (rc_data),
    .rot_amt (fld_t),
    .result  (alu_result),
    .writes  (alu_writes)
  );

  // machine cycle sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_FETCH_HI;
      pc_q     <= '0;
      ir_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_FETCH_HI: begin
          ir_q[INSTR_W-1:DATA_W] <= mem_rdata;
          pc_q    <= pc_q + ADDR_W'(1);
          state_q <= ST_FETCH_LO;
        end
        ST_FETCH_LO: begin
          ir_q[DATA_W-1:0] <= mem_rdata;
          pc_q    <= pc_q + ADDR_W'(1);
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (halt_fire) begin
            state_q  <= ST_HALT;
            halted_q <= 1'b1;
          end else begin
            state_q <= ST_FETCH_HI;
          end
          if (jump_taken) pc_q <= ADDR_W'(imm);
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign halted = halted_q;

  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    exec_fire |-> pc_q == ADDR_W'($past(pc_q, 2) + 2)); // R2

  AST_JUMP_LANDS: assert property (@(posedge clk) disable iff (rst)
    jump_taken |=> pc_q == ADDR_W'($past(imm))); // R9

  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> ($past(op) == OP_HLT && $past(state_q) == ST_EXEC)); // R10

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc_q))); // R10

  AST_HALT_NO_WRITES: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!rf_we && !mem_cpu_we)); // R10

  AST_NOP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (exec_fire && (op == 4'h0 || op == 4'h6 || op > OP_HLT))
      |-> (!rf_we && !mem_cpu_we && !jump_taken)); // R11

endmodule

// File: tb/hexcore_cpu_bench.sv
module hexcore_cpu_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dbg_we = 1'b0;
  logic [7:0] dbg_addr = '0;
  logic [7:0] dbg_wdata = '0;
  logic [7:0] dbg_rdata;
  logic       halted;

  int n_chk  = 0;
  int n_fail = 0;
  int at     = 0;

  hexcore_cpu u_hexcore_cpu (
    .clk       (clk),
    .rst       (rst),
    .dbg_we    (dbg_we),
    .dbg_addr  (dbg_addr),
    .dbg_wdata (dbg_wdata),
    .dbg_rdata (dbg_rdata),
    .halted    (halted)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ref_rot(input int v, input int n);
    int r = v & 8'hFF;
    for (int k = 0; k < (n % 8); k++) r = ((r & 1) << 7) | (r >> 1);
    return r;
  endfunction

  task automatic dwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic dread(input logic [7:0] a, output int d);
    @(negedge clk);
    dbg_addr = a;
    #1 d = int'(dbg_rdata);
  endtask

  task automatic emit(input logic [15:0] w);
    dwrite(8'(at), w[15:8]);
    dwrite(8'(at + 1), w[7:0]);
    at = (at + 2) % 256;
  endtask

  task automatic fresh();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 256; i++) dwrite(8'(i), 8'h00);
    at = 0;
  endtask

  task automatic run(input string req, input int n_instr);
    int cyc = 0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (halted) break;
    end
    chk(req, "cycles until halted", cyc, 3 * n_instr);
  endtask

  task automatic t_reset_and_port();
    int v;
    fresh();
    @(negedge clk);
    chk("R1", "halted in reset", int'(halted), 0);
    dwrite(8'h55, 8'hC3);
    dwrite(8'h56, 8'h3C);
    dread(8'h55, v); chk("R12", "side port cell 55", v, 8'hC3);
    dread(8'h56, v); chk("R12", "side port cell 56", v, 8'h3C);
  endtask

  task automatic t_load_store();
    int v;
    fresh();
    dwrite(8'h90, 8'hA5);
    emit(16'h213C); emit(16'h3180); emit(16'h1290); emit(16'h3281); emit(16'hC000);
    run("R2", 5);
    dread(8'h80, v); chk("R3", "literal load then store", v, 8'h3C);
    dread(8'h81, v); chk("R4", "memory load then store", v, 8'hA5);
  endtask

  task automatic t_alu();
    int v;
    fresh();
    emit(16'h20F0); emit(16'h213C);
    emit(16'h5301); emit(16'h33A0);
    emit(16'h7401); emit(16'h34A1);
    emit(16'h8501); emit(16'h35A2);
    emit(16'h9601); emit(16'h36A3);
    emit(16'h4017); emit(16'h37A4);
    emit(16'h2896); emit(16'hA803); emit(16'h38A5);
    emit(16'h2981); emit(16'hA900); emit(16'h39A6);
    emit(16'h2A81); emit(16'hAA09); emit(16'h3AA7);
    emit(16'hC000);
    run("R2", 22);
    dread(8'hA0, v); chk("R6", "wrapping add", v, (8'hF0 + 8'h3C) & 8'hFF);
    dread(8'hA1, v); chk("R7", "or", v, 8'hF0 | 8'h3C);
    dread(8'hA2, v); chk("R7", "and", v, 8'hF0 & 8'h3C);
    dread(8'hA3, v); chk("R7", "xor", v, 8'hF0 ^ 8'h3C);
    dread(8'hA4, v); chk("R5", "register copy", v, 8'h3C);
    dread(8'hA5, v); chk("R8", "rotate by 3", v, ref_rot(8'h96, 3));
    dread(8'hA6, v); chk("R8", "rotate by 0", v, 8'h81);
    dread(8'hA7, v); chk("R8", "rotate by 9", v, ref_rot(8'h81, 1));
  endtask

  task automatic t_jump();
    int v;
    fresh();
    dwrite(8'hC1, 8'hEE);
    dwrite(8'hC3, 8'hEE);
    emit(16'h2011); emit(16'h2122); emit(16'hB120); emit(16'h2201);
    emit(16'h32C0); emit(16'h2111); emit(16'hB130); emit(16'h32C1);
    at = 8'h20; emit(16'h32C3); emit(16'hC000);
    at = 8'h30; emit(16'h32C2); emit(16'hC000);
    run("R9", 9);
    dread(8'hC0, v); chk("R9", "fall-through when unequal", v, 8'h01);
    dread(8'hC1, v); chk("R9", "skipped after taken jump", v, 8'hEE);
    dread(8'hC2, v); chk("R9", "taken jump target", v, 8'h01);
    dread(8'hC3, v); chk("R9", "untaken target not run", v, 8'hEE);

    // PC wraps FE -> 00; B0XY always jumps; registers cleared by reset (R1)
    fresh();
    emit(16'hB620); emit(16'hC000);
    at = 8'h20; emit(16'h267E); emit(16'h2033); emit(16'hB0FE);
    at = 8'hFE; emit(16'h36C2);
    run("R2", 7);
    dread(8'hC2, v); chk("R2", "pc wrap and B0 jump", v, 8'h7E);
  endtask

  task automatic t_noop();
    int v;
    fresh();
    dwrite(8'h22, 8'h77);
    emit(16'h2144); emit(16'h0122); emit(16'h6122); emit(16'hD122);
    emit(16'hE122); emit(16'hF122); emit(16'h31D0); emit(16'hC000);
    run("R11", 8);
    dread(8'hD0, v); chk("R11", "register kept over no-ops", v, 8'h44);
    dread(8'h22, v); chk("R11", "cell kept over no-ops", v, 8'h77);
  endtask

  task automatic t_halt();
    int v;
    fresh();
    emit(16'h21AB); emit(16'hC000); emit(16'h31E0);
    run("R10", 2);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk("R10", "halted held", int'(halted), 1);
    dread(8'hE0, v); chk("R10", "no store after halt", v, 8'h00);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "reset clears halted", int'(halted), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_and_port();
    t_load_store();
    t_alu();
    t_jump();
    t_noop();
    t_halt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule